// File: doc/BRIEF.md
# Windowed Bus-to-Memory Address Translator

This block converts a 64-bit address seen on a peripheral bus into a system memory address. Four programmable windows are searched in a fixed priority order. A window claims an address when the address bits inside the window's compare range agree with the window base. That window then translates the address in one of two ways. A direct window replaces the high bits with a translated base. A scatter-gather window computes where a 64-bit page table entry sits in memory, reads that entry through a memory read port, and forms the result from the entry and the low bits of the bus address. An address that no enabled window claims is returned unchanged.

Software sets up the windows through a simple register port. The port also holds one 64-bit chip control word with a nonzero reset value. Translations enter through a valid/ready request and leave as a one-cycle response. A direct translation or a miss answers in the cycle after acceptance. A scatter-gather translation answers in the cycle after the memory read returns.

Top module: `bus_dma_xlate`

## Requirements
- R1: After reset, every window register reads zero, the control word reads 0x0000_0021_0010_0000, req_ready is 1, and rsp_valid and mem_req are 0.
- R2: The control word is at cfg_addr 3. All 64 bits can be written and read back.
- R3: The register address is split into two fields. cfg_addr[3:2] selects the window. cfg_addr[1:0] selects the register in that window: 0 is the base, 1 is the size mask and 2 is the translated base. Each of these registers reads back what was written. For windows 1 to 3, field 3 reads zero and a write to it has no effect.
- R4: The compare mask is ~mask & 0xFFF0_0000. A window claims an address when (addr & compare mask) equals (base & compare mask). Address bits outside bits 31:20 do not affect the match.
- R5: Base bit 0 enables a window. A window that claims an address while disabled is passed over, and the search goes on to the next window.
- R6: When more than one enabled window claims an address, the lowest-numbered window is used. Base bit 1 selects scatter-gather mode for that window.
- R7: In direct mode the offset mask is om = (mask & 0xFFF0_0000) | 0xFFFFF, and the result is (tbase & ~om) | (addr & om). rsp_valid is high in the cycle after the request is accepted.
- R8: When no enabled window claims the address, rsp_addr equals req_addr.
- R9: In scatter-gather mode, mem_req rises in the cycle after acceptance. mem_addr is then (tbase & ~(((mask & 0xFFF0_0000) >> 10) | 0x3FF)) | ((addr & ((mask & 0xFFF0_0000) | 0xFE000)) >> 10). Both mem_req and mem_addr are held until mem_rvalid.
- R10: The scatter-gather result is ((entry & ~1) << 12) | (addr & 0x1FFF), where entry is mem_rdata. rsp_valid is high in the cycle after mem_rvalid.
- R11: rsp_valid lasts exactly one cycle. req_ready is low from acceptance until the response cycle has ended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 4 | Register address: window index and field |
| cfg_wdata | input | 64 | Register write data |
| cfg_rdata | output | 64 | Read data for cfg_addr (combinational) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Ready to accept a request |
| req_addr | input | 64 | Bus address to translate |
| rsp_valid | output | 1 | Translation result valid (one cycle) |
| rsp_addr | output | 64 | Translated address |
| mem_req | output | 1 | Page table entry read request |
| mem_addr | output | 64 | Page table entry address |
| mem_rvalid | input | 1 | Page table entry read data valid |
| mem_rdata | input | 64 | Page table entry read data |

## Verification
The assertions rely on the memory side to answer each page table read with a single mem_rvalid pulse, and only while mem_req is high. The request side may raise req_valid at any time, because it only takes effect together with req_ready. The bench's memory model raises mem_rvalid for exactly one cycle, a fixed number of cycles after it sees mem_req. It never raises mem_rvalid without a pending read. The bench also changes the window registers only while no translation is in flight.

// File: rtl/bdx_pkg.sv
`timescale 1ns/1ps
package bdx_pkg;

  localparam int unsigned DW = 64;

  // bits of the mask register that take part in window sizing
  localparam logic [DW-1:0] SIZE_FIELD  = 64'h0000_0000_FFF0_0000;
  localparam logic [DW-1:0] DIRECT_LOW  = 64'h0000_0000_000F_FFFF;
  localparam logic [DW-1:0] PTE_LOW     = 64'h0000_0000_0000_03FF;
  localparam logic [DW-1:0] PAGE_IDX    = 64'h0000_0000_000F_E000;
  localparam logic [DW-1:0] PAGE_OFFSET = 64'h0000_0000_0000_1FFF;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_FETCH = 2'd1,
    ST_RESP  = 2'd2
  } seq_state_e;

  function automatic logic [DW-1:0] cmp_mask(input logic [DW-1:0] msk);
    return ~msk & SIZE_FIELD;
  endfunction

  function automatic logic win_claims(input logic [DW-1:0] addr,
                                      input logic [DW-1:0] base,
                                      input logic [DW-1:0] msk);
    logic [DW-1:0] cm;
    cm = cmp_mask(msk);
    return (addr & cm) == (base & cm);
  endfunction

  function automatic logic [DW-1:0] direct_xlate(input logic [DW-1:0] addr,
                                                 input logic [DW-1:0] msk,
                                                 input logic [DW-1:0] tbase);
    logic [DW-1:0] om;
    om = (msk & SIZE_FIELD) | DIRECT_LOW;
    return (tbase & ~om) | (addr & om);
  endfunction

  function automatic logic [DW-1:0] sg_pte_addr(input logic [DW-1:0] addr,
                                                input logic [DW-1:0] msk,
                                                input logic [DW-1:0] tbase);
    logic [DW-1:0] sized;
    logic [DW-1:0] tb_keep;
    logic [DW-1:0] idx_sel;
    sized   = msk & SIZE_FIELD;
    tb_keep = ~((sized >> 10) | PTE_LOW);
    idx_sel = sized | PAGE_IDX;
    return (tbase & tb_keep) | ((addr & idx_sel) >> 10);
  endfunction

  function automatic logic [DW-1:0] sg_result(input logic [DW-1:0] addr,
                                              input logic [DW-1:0] entry);
    return ((entry & ~64'h1) << 12) | (addr & PAGE_OFFSET);
  endfunction

endpackage

// File: rtl/bdx_regfile.sv
`timescale 1ns/1ps
module bdx_regfile
  import bdx_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000,
  localparam int RA_W  = $clog2(NUM_WIN) + 2,
  localparam int IDX_W = RA_W - 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_en,
  input  logic [RA_W-1:0] addr,
  input  logic [DW-1:0]   wdata,
  output logic [DW-1:0]   rdata,
  output logic [DW-1:0]   win_base  [NUM_WIN],
  output logic [DW-1:0]   win_mask  [NUM_WIN],
  output logic [DW-1:0]   win_tbase [NUM_WIN]
);

  localparam logic [1:0] F_BASE  = 2'd0;
  localparam logic [1:0] F_MASK  = 2'd1;
  localparam logic [1:0] F_TBASE = 2'd2;
  localparam logic [1:0] F_CTRL  = 2'd3;

  logic [IDX_W-1:0] idx;
  logic [1:0]       fld;
  logic [DW-1:0]    ctrl_q;
  logic             ctrl_sel;

  assign idx      = addr[RA_W-1:2];
  assign fld      = addr[1:0];
  assign ctrl_sel = (idx == '0) && (fld == F_CTRL);

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    logic sel;
    assign sel = wr_en && (idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        win_base[w]  <= '0;
        win_mask[w]  <= '0;
        win_tbase[w] <= '0;
      end else if (sel) begin
        if (fld == F_BASE)  win_base[w]  <= wdata;
        if (fld == F_MASK)  win_mask[w]  <= wdata;
        if (fld == F_TBASE) win_tbase[w] <= wdata;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 ctrl_q <= CTRL_RST;
    else if (wr_en && ctrl_sel) ctrl_q <= wdata;
  end

  always_comb begin
    rdata = '0;
    for (int w = 0; w < NUM_WIN; w++) begin
      if (idx == IDX_W'(w)) begin
        unique case (fld)
          F_BASE:  rdata = win_base[w];
          F_MASK:  rdata = win_mask[w];
          F_TBASE: rdata = win_tbase[w];
          default: rdata = ctrl_sel ? ctrl_q : '0;
        endcase
      end
    end
  end

endmodule

// File: rtl/bdx_window_match.sv
`timescale 1ns/1ps
module bdx_window_match
  import bdx_pkg::*;
#(
  parameter int NUM_WIN = 4
) (
  input  logic [DW-1:0]      addr,
  input  logic [DW-1:0]      win_base  [NUM_WIN],
  input  logic [DW-1:0]      win_mask  [NUM_WIN],
  input  logic [DW-1:0]      win_tbase [NUM_WIN],
  output logic               hit_any,
  output logic               hit_sg,
  output logic [NUM_WIN-1:0] hit_vec,
  output logic [DW-1:0]      direct_addr,
  output logic [DW-1:0]      pte_addr
);

  logic [DW-1:0] cand_direct [NUM_WIN];
  logic [DW-1:0] cand_pte    [NUM_WIN];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_cmp
    assign hit_vec[w]     = win_base[w][0] && win_claims(addr, win_base[w], win_mask[w]);
    assign cand_direct[w] = direct_xlate(addr, win_mask[w], win_tbase[w]);
    assign cand_pte[w]    = sg_pte_addr(addr, win_mask[w], win_tbase[w]);
  end

  // walk from the highest window down so the lowest claiming one wins
  always_comb begin
    hit_any     = 1'b0;
    hit_sg      = 1'b0;
    direct_addr = addr;
    pte_addr    = '0;
    for (int w = NUM_WIN - 1; w >= 0; w--) begin
      if (hit_vec[w]) begin
        hit_any     = 1'b1;
        hit_sg      = win_base[w][1];
        direct_addr = cand_direct[w];
        pte_addr    = cand_pte[w];
      end
    end
  end

endmodule

// File: rtl/bdx_seq.sv
`timescale 1ns/1ps
module bdx_seq
  import bdx_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [DW-1:0] req_addr,
  input  logic          hit_sg,
  input  logic [DW-1:0] direct_addr,
  input  logic [DW-1:0] pte_addr,
  output logic          mem_req,
  output logic [DW-1:0] mem_addr,
  input  logic          mem_rvalid,
  input  logic [DW-1:0] mem_rdata,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_addr,
  output logic          accept_evt,
  output logic          accept_sg_evt
);

  seq_state_e    state_q;
  logic [DW-1:0] bus_q;
  logic [DW-1:0] pte_q;
  logic [DW-1:0] rsp_q;

  assign req_ready     = (state_q == ST_IDLE);
  assign accept_evt    = req_valid && req_ready;
  assign accept_sg_evt = accept_evt && hit_sg;
  assign mem_req       = (state_q == ST_FETCH);
  assign mem_addr      = pte_q;
  assign rsp_valid     = (state_q == ST_RESP);
  assign rsp_addr      = rsp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      bus_q   <= '0;
      pte_q   <= '0;
      rsp_q   <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept_sg_evt) begin
            bus_q   <= req_addr;
            pte_q   <= pte_addr;
            state_q <= ST_FETCH;
          end else if (accept_evt) begin
            rsp_q   <= direct_addr;
            state_q <= ST_RESP;
          end
        end
        ST_FETCH: begin
          if (mem_rvalid) begin
            rsp_q   <= sg_result(bus_q, mem_rdata);
            state_q <= ST_RESP;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/bus_dma_xlate.sv
`timescale 1ns/1ps
module bus_dma_xlate
  import bdx_pkg::*;
#(
  parameter int NUM_WIN = 4,
  parameter logic [63:0] CTRL_RST = 64'h0000_0021_0010_0000,
  localparam int RA_W = $clog2(NUM_WIN) + 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_wr,
  input  logic [RA_W-1:0] cfg_addr,
  input  logic [63:0]     cfg_wdata,
  output logic [63:0]     cfg_rdata,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [63:0]     req_addr,
  output logic            rsp_valid,
  output logic [63:0]     rsp_addr,
  output logic            mem_req,
  output logic [63:0]     mem_addr,
  input  logic            mem_rvalid,
  input  logic [63:0]     mem_rdata
);

  logic [DW-1:0]      win_base  [NUM_WIN];
  logic [DW-1:0]      win_mask  [NUM_WIN];
  logic [DW-1:0]      win_tbase [NUM_WIN];
  logic               hit_any;
  logic               hit_sg;
  logic [NUM_WIN-1:0] hit_vec;
  logic [DW-1:0]      direct_addr;
  logic [DW-1:0]      pte_addr;
  logic               acc_evt;
  logic               acc_sg_evt;

  bdx_regfile #(.NUM_WIN(NUM_WIN), .CTRL_RST(CTRL_RST)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (cfg_wr),
    .addr      (cfg_addr),
    .wdata     (cfg_wdata),
    .rdata     (cfg_rdata),
    .win_base  (win_base),
    .win_mask  (win_mask),
    .win_tbase (win_tbase)
  );

  bdx_window_match #(.NUM_WIN(NUM_WIN)) u_match (
    .addr        (req_addr),
    .win_base    (win_base),
    .win_mask    (win_mask),
    .win_tbase   (win_tbase),
    .hit_any     (hit_any),
    .hit_sg      (hit_sg),
    .hit_vec     (hit_vec),
    .direct_addr (direct_addr),
    .pte_addr    (pte_addr)
  );

  bdx_seq u_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_addr      (req_addr),
    .hit_sg        (hit_sg),
    .direct_addr   (direct_addr),
    .pte_addr      (pte_addr),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_rvalid    (mem_rvalid),
    .mem_rdata     (mem_rdata),
    .rsp_valid     (rsp_valid),
    .rsp_addr      (rsp_addr),
    .accept_evt    (acc_evt),
    .accept_sg_evt (acc_sg_evt)
  );

endmodule

// File: rtl/bdx_chk.sv
`timescale 1ns/1ps
module bdx_chk #(
  parameter int NUM_WIN = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               mem_req,
  input logic [63:0]        mem_addr,
  input logic               mem_rvalid,
  input logic               accept_evt,
  input logic               accept_sg_evt,
  input logic               hit_any,
  input logic [NUM_WIN-1:0] hit_vec
);

  // R11
  rsp_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R11
  busy_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid || mem_req) |-> !req_ready);

  // R7
  direct_next_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && !accept_sg_evt) |=> rsp_valid);

  // R9
  sg_fetch_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_sg_evt |=> (mem_req && !rsp_valid));

  // R9
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R10
  fetch_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_rvalid) |=> (rsp_valid && !mem_req));

  // R5
  sg_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_sg_evt |-> (hit_any && (hit_vec != '0)));

endmodule

bind bus_dma_xlate bdx_chk #(.NUM_WIN(NUM_WIN)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .mem_req       (mem_req),
  .mem_addr      (mem_addr),
  .mem_rvalid    (mem_rvalid),
  .accept_evt    (acc_evt),
  .accept_sg_evt (acc_sg_evt),
  .hit_any       (hit_any),
  .hit_vec       (hit_vec)
);

// File: tb/bus_dma_xlate_bench.sv
`timescale 1ns/1ps
module bus_dma_xlate_bench;

  localparam int NV = 10;
  localparam logic [63:0] ENTRY = 64'h0000_0000_0003_4561;

  // address, expected result, scatter-gather flag, expected entry address
  localparam logic [63:0] VA [NV] = '{
    64'h0000_0000_4123_4567, 64'hFFFF_0000_4123_4567, 64'h0000_0000_9ABC_DEF0,
    64'h0000_0000_2000_0000, 64'hDEAD_0000_1234_5678, 64'h0000_0000_8012_3456,
    64'h0000_0000_C000_0010, 64'h0000_0000_4FFF_FFFF, 64'h0000_0000_3FFF_FFFF,
    64'h0000_0000_80FF_FFFF };
  localparam logic [63:0] VE [NV] = '{
    64'h0000_0001_0123_4567, 64'h0000_0001_0123_4567, 64'h0000_0007_1ABC_DEF0,
    64'h0000_0000_2000_0000, 64'hDEAD_0000_1234_5678, 64'h0000_0000_3456_1456,
    64'h0000_0007_4000_0010, 64'h0000_0001_0FFF_FFFF, 64'h0000_0000_3FFF_FFFF,
    64'h0000_0000_3456_1FFF };
  localparam logic [NV-1:0] VSG = 10'b10_0010_0000;
  localparam logic [63:0] VP [NV] = '{
    64'h0, 64'h0, 64'h0, 64'h0, 64'h0, 64'h0000_0000_0200_0488,
    64'h0, 64'h0, 64'h0, 64'h0000_0000_0200_3FF8 };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr = 1'b0;
  logic [3:0]  cfg_addr = '0;
  logic [63:0] cfg_wdata = '0;
  logic [63:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [63:0] req_addr = '0;
  logic        rsp_valid;
  logic [63:0] rsp_addr;
  logic        mem_req;
  logic [63:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [63:0] mem_rdata = '0;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [63:0] last_pte = '0;

  always #4 clk = ~clk;

  bus_dma_xlate u_bus_dma_xlate (
    .clk(clk), .rst_n(rst_n),
    .cfg_wr(cfg_wr), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
  );

  function automatic string vec_tag(input int i);
    case (i)
      0: return "R7 direct window 0";
      1: return "R4 upper bits ignored";
      2: return "R5 disabled window skipped";
      3: return "R8 miss passthrough";
      4: return "R8 miss high bits kept";
      5: return "R6 R10 lowest window wins, scatter-gather";
      6: return "R7 direct window 3";
      7: return "R4 top of window 0";
      8: return "R4 R8 just below window 0";
      default: return "R9 R10 scatter-gather top of range";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [3:0] a, input logic [63:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic cfg_read(input logic [3:0] a, output logic [63:0] d);
    @(negedge clk);
    cfg_addr = a;
    #1;
    d = cfg_rdata;
  endtask

  task automatic xlate(input logic [63:0] a, input bit sg, input logic [63:0] exp,
                       input logic [63:0] exp_pte, input string tag);
    int cnt;
    @(negedge clk);
    req_valid = 1'b1; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    if (!sg) begin
      chk({tag, " R7 response next cycle"}, 64'(rsp_valid), 64'd1);
    end else begin
      cnt = 0;
      chk({tag, " R11 busy during fetch"}, 64'(req_ready), 64'd0);
      while (!rsp_valid && cnt < 20) begin
        @(negedge clk);
        cnt++;
      end
      chk({tag, " R10 response seen"}, 64'(rsp_valid), 64'd1);
      chk({tag, " R9 entry address"}, last_pte, exp_pte);
    end
    chk({tag, " result"}, rsp_addr, exp);
    @(negedge clk);
    chk({tag, " R11 pulse ends, ready again"}, {62'd0, rsp_valid, req_ready}, 64'd1);
  endtask

  // memory model: answers a pending read three cycles after it appears
  initial begin
    int wait_cnt;
    wait_cnt = 0;
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        wait_cnt = 0;
      end else if (mem_req) begin
        wait_cnt++;
        if (wait_cnt == 3) begin
          mem_rvalid = 1'b1;
          mem_rdata  = ENTRY;
          last_pte   = mem_addr;
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [63:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 16; a++) begin
      cfg_read(4'(a), d);
      chk($sformatf("R1 reset read addr %0d", a), d, (a == 3) ? 64'h0000_0021_0010_0000 : 64'h0);
    end
    chk("R1 reset handshake", {61'd0, req_ready, rsp_valid, mem_req}, 64'd4);

    // R2 control word
    cfg_write(4'd3, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_read(4'd3, d);
    chk("R2 control all ones", d, 64'hFFFF_FFFF_FFFF_FFFF);
    cfg_write(4'd3, 64'h0123_4567_89AB_CDEF);
    cfg_read(4'd3, d);
    chk("R2 control pattern", d, 64'h0123_4567_89AB_CDEF);

    // window setup: 0 direct, 1 scatter-gather, 2 disabled, 3 direct catch-all
    cfg_write(4'd0,  64'h0000_0000_4000_0001);
    cfg_write(4'd1,  64'h0000_0000_0FF0_0000);
    cfg_write(4'd2,  64'h0000_0001_0000_0000);
    cfg_write(4'd4,  64'h0000_0000_8000_0003);
    cfg_write(4'd5,  64'h0000_0000_00F0_0000);
    cfg_write(4'd6,  64'h0000_0000_0200_0000);
    cfg_write(4'd8,  64'h0000_0000_9000_0000);
    cfg_write(4'd9,  64'h0000_0000_0FF0_0000);
    cfg_write(4'd10, 64'h0000_0005_0000_0000);
    cfg_write(4'd12, 64'h0000_0000_8000_0001);
    cfg_write(4'd13, 64'h0000_0000_7FF0_0000);
    cfg_write(4'd14, 64'h0000_0007_0000_0000);

    // R3 readback and ignored field
    cfg_read(4'd5, d);  chk("R3 window 1 mask", d, 64'h0000_0000_00F0_0000);
    cfg_read(4'd14, d); chk("R3 window 3 tbase", d, 64'h0000_0007_0000_0000);
    cfg_write(4'd7, 64'hAAAA_AAAA_AAAA_AAAA);
    cfg_read(4'd7, d);  chk("R3 unused field reads zero", d, 64'h0);
    cfg_read(4'd6, d);  chk("R3 neighbour unchanged", d, 64'h0000_0000_0200_0000);
    cfg_read(4'd3, d);  chk("R3 control unchanged", d, 64'h0123_4567_89AB_CDEF);

    // vector table
    for (int i = 0; i < NV; i++) begin
      xlate(VA[i], VSG[i], VE[i], VP[i], vec_tag(i));
    end

    // R5: enabling window 2 makes it claim ahead of window 3
    cfg_write(4'd8, 64'h0000_0000_9000_0001);
    xlate(64'h0000_0000_9ABC_DEF0, 1'b0, 64'h0000_0005_0ABC_DEF0, 64'h0, "R5 enabled window 2");
    // R5: disabling window 0 lets its addresses fall through
    cfg_write(4'd0, 64'h0000_0000_4000_0000);
    xlate(64'h0000_0000_4123_4567, 1'b0, 64'h0000_0000_4123_4567, 64'h0, "R5 R8 window 0 off");

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule